// File: doc/BRIEF.md
# Poison-Tracking General Register File

This block is a general-purpose register file in which every register carries a poison flag next to its data. The flag marks a deferred fault left by speculative execution. A speculative load that would have faulted does not trap. It writes its destination and raises that register's flag. Ordinary ALU results take the OR of their two sources' flags, so poison spreads down a chain of dependent results. A single check at the end of the chain is then enough to catch a fault anywhere along it.

The file has one write port, two registered read ports and a check port. The check port raises a one-cycle recovery request when the named register is poisoned. Every write and every check is qualified by a one-bit predicate, chosen by a 6-bit index into a 64-entry predicate file. That predicate file has its own plain write port. Register 0 is hard-wired to zero, and so is predicate 0's value of one.

Top module: `poison_regfile`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), every poison flag is clear, all read outputs, chk_fire and chk_target_out are 0, predicate 0 is 1 and predicates 1 to 63 are 0. Data words are defined only once they have been written.
- R2: The read index sampled at a clock edge selects the data and poison flag that appear on that port's outputs after that edge, one cycle of latency, for both read ports independently.
- R3: When a committing write and a read, or a check, name the same register in the same cycle, the read outputs and the check use the value and poison flag being written.
- R4: An ALU write (wr_kind 2'b00, and the unused code 2'b11 behaves the same) stores wr_data and a poison flag equal to the OR of the stored flags of wr_src_a and wr_src_b, taken before this cycle's write.
- R5: A speculative load write (wr_kind 2'b10) stores wr_data with its poison flag equal to wr_fault: a faulting access poisons the destination and raises nothing else.
- R6: A normal load write (wr_kind 2'b01) stores wr_data with a clear poison flag, whatever wr_fault is.
- R7: A write commits only when predicate wr_pred is 1, and a check acts only when predicate chk_pred is 1. A predicate write (pr_we) to index pr_idx takes effect from the next cycle, and predicate writes to index 0 are ignored.
- R8: Register 0 always reads as zero data with a clear flag. Writes to it are ignored.
- R9: A check (chk_en with its predicate true) on a poisoned register raises chk_fire for exactly the next cycle, with chk_target_out equal to the chk_target given. In every other case chk_fire is 0 and chk_target_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_kind | input | 2 | 00 ALU, 01 load, 10 speculative load, 11 as ALU |
| wr_dst | input | 7 | Destination register |
| wr_data | input | 64 | Result data |
| wr_src_a | input | 7 | First source register of an ALU result |
| wr_src_b | input | 7 | Second source register of an ALU result |
| wr_fault | input | 1 | Access fault flag of a load |
| wr_pred | input | 6 | Predicate index qualifying the write |
| pr_we | input | 1 | Predicate write enable |
| pr_idx | input | 6 | Predicate index to write |
| pr_val | input | 1 | Predicate value to write |
| rd_a_idx | input | 7 | Read port A index |
| rd_b_idx | input | 7 | Read port B index |
| rd_a_data | output | 64 | Read port A data |
| rd_a_nat | output | 1 | Read port A poison flag |
| rd_b_data | output | 64 | Read port B data |
| rd_b_nat | output | 1 | Read port B poison flag |
| chk_en | input | 1 | Check request |
| chk_reg | input | 7 | Register to check |
| chk_pred | input | 6 | Predicate index qualifying the check |
| chk_target | input | 64 | Recovery target carried by the check |
| chk_fire | output | 1 | Recovery request pulse |
| chk_target_out | output | 64 | Recovery target while chk_fire is high |

## Verification
Both read ports and the check pulse are registered. A request driven in one cycle therefore shows its result right after the next rising edge, while a write changes what later operations see from that same edge on. The bench drives inputs on the falling edge. Its model works out each result from the state before the write, with the same-cycle forwarding applied, then updates that state and compares the outputs on the following falling edge. Every output is checked in every cycle this way. Data read from a register that has never been written is left unchecked.

// File: rtl/natrf_pkg.sv
package natrf_pkg;
  typedef enum logic [1:0] {
    K_ALU  = 2'b00,
    K_LOAD = 2'b01,
    K_SPEC = 2'b10,
    K_RSV  = 2'b11
  } wkind_e;
endpackage

// File: rtl/pred_file.sv
module pred_file #(
  parameter int NPRED = 64,
  localparam int PW = $clog2(NPRED)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [PW-1:0] widx,
  input  logic          wval,
  input  logic [PW-1:0] ridx_w,
  input  logic [PW-1:0] ridx_c,
  output logic          pred_w,
  output logic          pred_c
);
  logic [NPRED-1:0] pq;

  always_ff @(posedge clk) begin
    if (rst) begin
      pq    <= '0;
      pq[0] <= 1'b1;
    end else if (we && widx != '0) begin
      pq[widx] <= wval;
    end
  end

  assign pred_w = pq[ridx_w];
  assign pred_c = pq[ridx_c];

  // R7: a predicate write lands in the next cycle
  assert_pred_write_R7: assert property (@(posedge clk) disable iff (rst)
    (we && widx != '0) |=> pq[$past(widx)] == $past(wval));
  // R7: predicate 0 keeps its value of one
  assert_pred_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (we && widx == '0) |=> pq[0]);
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int NREG = 128,
  parameter int DW   = 64,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic                    wnat,
  input  logic [NRD-1:0][AW-1:0]  ridx,
  output logic [NRD-1:0][DW-1:0]  rdata,
  output logic [NRD-1:0]          rnat,
  output logic [NREG-1:0]         nat_vec
);
  logic [DW-1:0]   mem [NREG];
  logic [NREG-1:0] nat_q;
  logic            wr_ok;

  assign wr_ok   = we && (waddr != '0);
  assign nat_vec = nat_q;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        nat_q <= '0;
    else if (wr_ok) nat_q[waddr] <= wnat;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [DW-1:0] dq;
    logic          nq;
    always_ff @(posedge clk) begin
      if (rst || ridx[p] == '0) begin
        dq <= '0;
        nq <= 1'b0;
      end else if (wr_ok && waddr == ridx[p]) begin
        dq <= wdata;
        nq <= wnat;
      end else begin
        dq <= mem[ridx[p]];
        nq <= nat_q[ridx[p]];
      end
    end
    assign rdata[p] = dq;
    assign rnat[p]  = nq;

    // R3: a read that meets a write returns the written value
    assert_fwd_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_ok && waddr == ridx[p]) |=> (dq == $past(wdata) && nq == $past(wnat)));
  end

  // R4: the stored poison flag follows the write
  assert_nat_store_R4: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> nat_q[$past(waddr)] == $past(wnat));
  // R8: register 0 never becomes poisoned
  assert_r0_clean_R8: assert property (@(posedge clk) disable iff (rst) !nat_q[0]);
endmodule

// File: rtl/poison_regfile.sv
module poison_regfile #(
  parameter int NREG  = 128,
  parameter int DW    = 64,
  parameter int NPRED = 64,
  parameter int TGT_W = 64,
  localparam int AW = $clog2(NREG),
  localparam int PW = $clog2(NPRED)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_kind,
  input  logic [AW-1:0]    wr_dst,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    wr_src_a,
  input  logic [AW-1:0]    wr_src_b,
  input  logic             wr_fault,
  input  logic [PW-1:0]    wr_pred,
  input  logic             pr_we,
  input  logic [PW-1:0]    pr_idx,
  input  logic             pr_val,
  input  logic [AW-1:0]    rd_a_idx,
  input  logic [AW-1:0]    rd_b_idx,
  output logic [DW-1:0]    rd_a_data,
  output logic             rd_a_nat,
  output logic [DW-1:0]    rd_b_data,
  output logic             rd_b_nat,
  input  logic             chk_en,
  input  logic [AW-1:0]    chk_reg,
  input  logic [PW-1:0]    chk_pred,
  input  logic [TGT_W-1:0] chk_target,
  output logic             chk_fire,
  output logic [TGT_W-1:0] chk_target_out
);
  import natrf_pkg::*;

  logic            pred_w, pred_c;
  logic            commit, nat_new, chk_nat, fire_d;
  logic [NREG-1:0] nat_vec;
  logic [1:0][AW-1:0] ridx;
  logic [1:0][DW-1:0] rdata;
  logic [1:0]         rnat;
  wkind_e          kind;

  pred_file #(.NPRED(NPRED)) i_pred (
    .clk(clk), .rst(rst), .we(pr_we), .widx(pr_idx), .wval(pr_val),
    .ridx_w(wr_pred), .ridx_c(chk_pred), .pred_w(pred_w), .pred_c(pred_c)
  );

  assign kind   = wkind_e'(wr_kind);
  assign commit = wr_en && pred_w;

  always_comb begin
    unique case (kind)
      K_LOAD:  nat_new = 1'b0;
      K_SPEC:  nat_new = wr_fault;
      default: nat_new = nat_vec[wr_src_a] | nat_vec[wr_src_b];
    endcase
  end

  assign ridx = {rd_b_idx, rd_a_idx};

  reg_bank #(.NREG(NREG), .DW(DW), .NRD(2)) i_bank (
    .clk(clk), .rst(rst), .we(commit), .waddr(wr_dst), .wdata(wr_data),
    .wnat(nat_new), .ridx(ridx), .rdata(rdata), .rnat(rnat), .nat_vec(nat_vec)
  );

  assign rd_a_data = rdata[0];
  assign rd_a_nat  = rnat[0];
  assign rd_b_data = rdata[1];
  assign rd_b_nat  = rnat[1];

  always_comb begin
    if (chk_reg == '0)                       chk_nat = 1'b0;
    else if (commit && wr_dst == chk_reg)    chk_nat = nat_new;
    else                                     chk_nat = nat_vec[chk_reg];
  end

  assign fire_d = chk_en && pred_c && chk_nat;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_fire       <= 1'b0;
      chk_target_out <= '0;
    end else begin
      chk_fire       <= fire_d;
      chk_target_out <= fire_d ? chk_target : '0;
    end
  end

  // R9: a recovery pulse always follows a check request
  assert_fire_cause_R9: assert property (@(posedge clk) disable iff (rst)
    chk_fire |-> $past(chk_en));
  // R5: a faulting speculative load poisons its destination
  assert_spec_poison_R5: assert property (@(posedge clk) disable iff (rst)
    (commit && kind == K_SPEC && wr_fault && wr_dst != '0) |=> nat_vec[$past(wr_dst)]);
  // R6: a normal load leaves a clean destination
  assert_load_clean_R6: assert property (@(posedge clk) disable iff (rst)
    (commit && kind == K_LOAD) |=> !nat_vec[$past(wr_dst)]);
  // R7: a write with a false predicate leaves every flag untouched
  assert_pred_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !pred_w) |=> $stable(nat_vec));
  // R8: reading register 0 yields zero
  assert_r0_read_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_a_idx) == '0) |-> (rd_a_data == '0 && !rd_a_nat));
endmodule

// File: tb/test_poison_regfile.sv
module test_poison_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0, wr_fault = 0, pr_we = 0, pr_val = 0, chk_en = 0;
  logic [1:0]  wr_kind = 0;
  logic [6:0]  wr_dst = 0, wr_src_a = 0, wr_src_b = 0, rd_a_idx = 0, rd_b_idx = 0, chk_reg = 0;
  logic [5:0]  wr_pred = 0, pr_idx = 0, chk_pred = 0;
  logic [63:0] wr_data = 0, chk_target = 0;
  logic [63:0] rd_a_data, rd_b_data, chk_target_out;
  logic        rd_a_nat, rd_b_nat, chk_fire;

  int tests = 0, fails = 0;
  string cur_req = "R1";

  logic [63:0] ref_data [128];
  bit          ref_nat  [128];
  bit          ref_vld  [128];
  bit          ref_pred [64];

  always #10 clk = ~clk;

  poison_regfile i_poison_regfile (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_dst(wr_dst),
    .wr_data(wr_data), .wr_src_a(wr_src_a), .wr_src_b(wr_src_b), .wr_fault(wr_fault),
    .wr_pred(wr_pred), .pr_we(pr_we), .pr_idx(pr_idx), .pr_val(pr_val),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx), .rd_a_data(rd_a_data), .rd_a_nat(rd_a_nat),
    .rd_b_data(rd_b_data), .rd_b_nat(rd_b_nat), .chk_en(chk_en), .chk_reg(chk_reg),
    .chk_pred(chk_pred), .chk_target(chk_target), .chk_fire(chk_fire),
    .chk_target_out(chk_target_out)
  );

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; pr_we = 0; chk_en = 0; wr_fault = 0;
  endtask

  // One clock: model result from pre-state, update model, compare after the edge.
  task automatic step();
    bit commit, nn, ea_v, eb_v, ea_n, eb_n, cn, efire;
    logic [63:0] ea_d, eb_d, etgt;
    commit = wr_en && ref_pred[wr_pred] && (wr_dst != 0);
    case (wr_kind)
      2'b01:   nn = 0;
      2'b10:   nn = wr_fault;
      default: nn = ref_nat[wr_src_a] | ref_nat[wr_src_b];
    endcase
    if (rd_a_idx == 0) begin ea_d = 0; ea_n = 0; ea_v = 1; end
    else if (commit && wr_dst == rd_a_idx) begin ea_d = wr_data; ea_n = nn; ea_v = 1; end
    else begin ea_d = ref_data[rd_a_idx]; ea_n = ref_nat[rd_a_idx]; ea_v = ref_vld[rd_a_idx]; end
    if (rd_b_idx == 0) begin eb_d = 0; eb_n = 0; eb_v = 1; end
    else if (commit && wr_dst == rd_b_idx) begin eb_d = wr_data; eb_n = nn; eb_v = 1; end
    else begin eb_d = ref_data[rd_b_idx]; eb_n = ref_nat[rd_b_idx]; eb_v = ref_vld[rd_b_idx]; end
    if (chk_reg == 0) cn = 0;
    else if (commit && wr_dst == chk_reg) cn = nn;
    else cn = ref_nat[chk_reg];
    efire = chk_en && ref_pred[chk_pred] && cn;
    etgt  = efire ? chk_target : 64'h0;
    if (commit) begin
      ref_data[wr_dst] = wr_data; ref_nat[wr_dst] = nn; ref_vld[wr_dst] = 1;
    end
    if (pr_we && pr_idx != 0) ref_pred[pr_idx] = pr_val;
    @(posedge clk);
    @(negedge clk);
    check(rd_a_nat == ea_n, "port A poison", 64'(rd_a_nat), 64'(ea_n));
    check(rd_b_nat == eb_n, "port B poison", 64'(rd_b_nat), 64'(eb_n));
    if (ea_v) check(rd_a_data == ea_d, "port A data", rd_a_data, ea_d);
    if (eb_v) check(rd_b_data == eb_d, "port B data", rd_b_data, eb_d);
    check(chk_fire == efire, "check pulse", 64'(chk_fire), 64'(efire));
    check(chk_target_out == etgt, "check target", chk_target_out, etgt);
  endtask

  task automatic wr(input logic [1:0] k, input int d, input logic [63:0] v,
                    input int a, input int b, input bit f, input int p);
    wr_en = 1; wr_kind = k; wr_dst = 7'(d); wr_data = v;
    wr_src_a = 7'(a); wr_src_b = 7'(b); wr_fault = f; wr_pred = 6'(p);
  endtask

  task automatic rd(input int a, input int b);
    rd_a_idx = 7'(a); rd_b_idx = 7'(b);
  endtask

  task automatic ck(input int r, input int p, input logic [63:0] t);
    chk_en = 1; chk_reg = 7'(r); chk_pred = 6'(p); chk_target = t;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 128; i++) begin ref_data[i] = 0; ref_nat[i] = 0; ref_vld[i] = 0; end
    for (int i = 0; i < 64; i++) ref_pred[i] = 0;
    ref_pred[0] = 1; ref_vld[0] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state on all outputs
    cur_req = "R1";
    check(rd_a_data == 0 && rd_b_data == 0, "read data after reset", rd_a_data | rd_b_data, 0);
    check(!rd_a_nat && !rd_b_nat && !chk_fire, "flags after reset", 64'(rd_a_nat | rd_b_nat | chk_fire), 0);
    check(chk_target_out == 0, "target after reset", chk_target_out, 0);
    rd(5, 6); ck(5, 0, 64'hAA); step(); idle();
    // R7: predicate setup; p1 true, p2 false
    cur_req = "R7";
    pr_we = 1; pr_idx = 1; pr_val = 1; step();
    pr_idx = 2; pr_val = 0; step(); idle();
    // R5: speculative loads, faulting and clean
    cur_req = "R5";
    wr(2'b10, 10, 64'h1010, 0, 0, 1, 1); step();
    wr(2'b10, 11, 64'h1111, 0, 0, 0, 0); rd(10, 0); step(); idle();
    // R6: normal load with fault input set stays clean
    cur_req = "R6";
    wr(2'b01, 12, 64'h1212, 0, 0, 1, 0); rd(10, 11); step(); idle();
    rd(12, 11); step();
    // R4: propagation through a chain
    cur_req = "R4";
    wr(2'b00, 13, 64'h1313, 10, 11, 0, 0); step();
    wr(2'b00, 14, 64'h1414, 11, 12, 0, 1); step();
    wr(2'b11, 15, 64'h1515, 13, 14, 0, 0); rd(13, 14); step(); idle();
    rd(15, 14); step();
    // R9: checks on poisoned and clean registers, and with false predicate
    cur_req = "R9";
    ck(15, 0, 64'hDEAD_0001); step();
    ck(14, 0, 64'hDEAD_0002); step();
    ck(15, 2, 64'hDEAD_0003); step(); idle(); step();
    // R7: gated write leaves old contents; predicate 0 cannot be cleared
    cur_req = "R7";
    wr(2'b10, 14, 64'hBAD, 0, 0, 1, 2); step(); idle();
    rd(14, 0); step();
    pr_we = 1; pr_idx = 0; pr_val = 0; step(); idle();
    wr(2'b01, 20, 64'h2020, 0, 0, 0, 0); rd(20, 14); step(); idle();
    // R3: same-cycle forwarding to reads and check
    cur_req = "R3";
    wr(2'b10, 22, 64'h2222, 0, 0, 1, 1); rd(22, 22); ck(22, 1, 64'hBEEF); step(); idle();
    wr(2'b01, 15, 64'h5151, 0, 0, 0, 0); ck(15, 0, 64'hCAFE); rd(15, 0); step(); idle();
    // R8: register 0 ignores writes
    cur_req = "R8";
    wr(2'b10, 0, 64'hFFFF, 0, 0, 1, 0); rd(0, 0); ck(0, 0, 64'h1); step(); idle();
    rd(0, 0); step();
    // R2: independent ports, one-cycle latency
    cur_req = "R2";
    rd(10, 20); step(); rd(22, 13); step();
    // R4: mixed random traffic
    cur_req = "R4";
    for (int i = 0; i < 600; i++) begin
      wr_en = 1'($urandom); wr_kind = 2'($urandom); wr_dst = 7'($urandom_range(0, 31));
      wr_data = {$urandom, $urandom}; wr_src_a = 7'($urandom_range(0, 31));
      wr_src_b = 7'($urandom_range(0, 31)); wr_fault = 1'($urandom);
      wr_pred = 6'($urandom_range(0, 3));
      pr_we = ($urandom_range(0, 7) == 0); pr_idx = 6'($urandom_range(0, 3)); pr_val = 1'($urandom);
      rd_a_idx = 7'($urandom_range(0, 31)); rd_b_idx = 7'($urandom_range(0, 31));
      chk_en = 1'($urandom); chk_reg = 7'($urandom_range(0, 31));
      chk_pred = 6'($urandom_range(0, 3)); chk_target = {$urandom, $urandom};
      step();
    end
    idle(); step();
    summary();
  end
endmodule